// File: doc/BRIEF.md
# Synchronous Presettable Binary Counter

This block is a small up-counter whose state changes only on the rising clock edge. Four control pins pick the operation for the next edge. In order of priority they are a clear to zero, a parallel load from a data bus, an increment, and a hold. The clear and the load are active low. The two increment enables are active high, and both must be high for the count to advance.

A terminal-count output lets several counters be chained into one wider synchronous counter. Tie the terminal-count output of one stage to the carry-enable of the next stage, and drive every stage's count enable from one shared signal. The terminal-count output is combinational from the carry-enable. A carry therefore ripples through the whole chain within one cycle and does not wait for a clock edge.

The width is a parameter with a default of 4 bits. The register has no defined value at power-up, so a clear must be applied before the count is used. There is no data stream at this edge: every pin is a plain level-sensitive control or status signal, sampled at the clock edge. There is no valid/ready handshake and no back-pressure.

Top module: `presettable_counter`

## Requirements
- R1: The count changes only on a rising clock edge. Pulling clr_n low between edges leaves the count unchanged until the next rising edge.
- R2: When clr_n is low at a rising edge, the count becomes 0 on that edge, whatever load_n, cnt_en and carry_en are.
- R3: When clr_n is high and load_n is low at a rising edge, the count takes the value of din on that edge, and cnt_en and carry_en have no effect. din bit 0 goes to count bit 0, which is the least significant bit.
- R4: When clr_n and load_n are both high and cnt_en and carry_en are both high, the count increases by one at the edge. The count wraps from all ones (15 at the default width) to 0.
- R5: When clr_n and load_n are both high and either cnt_en or carry_en is low, the count holds its value.
- R6: carry_out is high exactly when carry_en is high and the count is all ones. It follows carry_en combinationally, without waiting for a clock edge.
- R7: Two instances can be chained as a cascade. The low stage's carry_out drives the high stage's carry_en, and cnt_en is shared. The pair then counts from 0 to 255 and wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable; does not affect carry_out |
| carry_en | input | 1 | Carry enable; also gates carry_out |
| din | input | WIDTH | Parallel data for a load |
| count | output | WIDTH | Current count, bit 0 least significant |
| carry_out | output | 1 | Terminal count: carry_en AND count is all ones |

## Verification
Any wrong next-state choice shows on count right after the edge where it happens. A mode decoded with the wrong priority, a missed or extra increment, or a lost wrap each show within one clock. A carry that is wrong at the top value shows at carry_out straight away, with no clock edge needed. In a cascade it also shows as a high stage that advances at the wrong time, which the bench sees at the next edge. A fault in the ripple enable that only affects the upper bits appears only once the low bits reach all ones. That takes at most 2^WIDTH cycles, so the bench walks the full range and every wrap.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Operation selected for the coming clock edge, in priority order.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      cnt_en,
  input  logic      carry_en,
  output cnt_mode_e mode
);
  // The clear wins over the load, and the load wins over counting.
  always_comb begin
    if (!clr_n)                   mode = MODE_CLEAR;
    else if (!load_n)             mode = MODE_LOAD;
    else if (cnt_en && carry_en)  mode = MODE_COUNT;
    else                          mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_mode_e        mode,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  // Toggle-chain incrementer: a bit flips when every bit below it is one.
  logic [WIDTH:0]   all_low_ones;
  logic [WIDTH-1:0] inc;

  assign all_low_ones[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign inc[i]            = cur[i] ^ all_low_ones[i];
    assign all_low_ones[i+1] = all_low_ones[i] & cur[i];
  end

  always_comb begin
    unique case (mode)
      MODE_CLEAR: nxt = '0;
      MODE_LOAD:  nxt = din;
      MODE_COUNT: nxt = inc;
      default:    nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             carry_en,
  output logic             carry_out
);
  // Combinational from carry_en so a carry ripples through a cascade.
  assign carry_out = carry_en & (&count);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             carry_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry_out
);
  cnt_mode_e        mode;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  cnt_mode_dec u_dec (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .mode     (mode)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .mode (mode),
    .cur  (count_q),
    .din  (din),
    .nxt  (count_d)
  );

  // No asynchronous reset: the clear acts only through the edge.
  always_ff @(posedge clk) begin
    count_q <= count_d;
  end

  cnt_tc #(.WIDTH(WIDTH)) u_tc (
    .count     (count_q),
    .carry_en  (carry_en),
    .carry_out (carry_out)
  );

  assign count = count_q;
endmodule

// File: rtl/presettable_counter_chk.sv
module presettable_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             cnt_en,
  input logic             carry_en,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] count,
  input logic             carry_out
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // Set after the first clear; before it the register is undefined.
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clr_n) armed <= 1'b1;
  end

  // R2
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> count == '0);

  // R3
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n) |=> count == $past(din));

  // R4
  count_up_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && cnt_en && carry_en) |=> count == WIDTH'($past(count) + 1'b1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(cnt_en && carry_en)) |=> $stable(count));

  // R6
  carry_needs_top_chk: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> (carry_en && count == TOP));

  // R6
  carry_at_top_chk: assert property (@(posedge clk) disable iff (!armed)
    (carry_en && count == TOP) |-> carry_out);
endmodule

bind presettable_counter presettable_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .carry_en  (carry_en),
  .din       (din),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/presettable_counter_test.sv
`timescale 1ns/1ps
module presettable_counter_test;
  logic       clk = 1'b0;
  logic       clr_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, carry_en = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] count;
  logic       carry_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  presettable_counter #(.WIDTH(4)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din), .count(count), .carry_out(carry_out)
  );

  // Cascade of two stages for R7.
  logic       c_clr_n = 1'b1, c_en = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_carry, hi_carry;

  presettable_counter #(.WIDTH(4)) stage_lo (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en(c_en),
    .carry_en(1'b1), .din(4'd0), .count(lo_q), .carry_out(lo_carry)
  );
  presettable_counter #(.WIDTH(4)) stage_hi (
    .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .cnt_en(c_en),
    .carry_en(lo_carry), .din(4'd0), .count(hi_q), .carry_out(hi_carry)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one edge; inputs are then driven and outputs sampled 1 ns after it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_ctl(input logic c, input logic l, input logic e, input logic t);
    clr_n = c; load_n = l; cnt_en = e; carry_en = t;
  endtask

  task automatic t_clear();
    // R2: clear beats load and both enables
    set_ctl(1'b0, 1'b0, 1'b1, 1'b1); din = 4'd9;
    tick();
    check(count == 4'd0, "R2 clear over load", count, 0);
    // R1: clear pulled low between edges must wait for the edge
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0); din = 4'd5;
    tick();
    check(count == 4'd5, "R3 load before R1", count, 5);
    clr_n = 1'b0;
    #1;
    check(count == 4'd5, "R1 no async clear", count, 5);
    tick();
    check(count == 4'd0, "R1 clear at edge", count, 0);
  endtask

  task automatic t_load();
    // R3: enables ignored during load, bit order kept
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1); din = 4'b1010;
    tick();
    check(count == 4'd10, "R3 load with enables", count, 10);
    din = 4'b0001;
    tick();
    check(count == 4'd1, "R3 bit0 to lsb", count, 1);
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0); din = 4'd13;
    tick();
    check(count == 4'd13, "R3 load no enables", count, 13);
  endtask

  task automatic t_count();
    // R4: from 13 step through 14, 15 and wrap to 0
    set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    check(count == 4'd14, "R4 inc", count, 14);
    check(carry_out == 1'b0, "R6 no carry below top", carry_out, 0);
    tick();
    check(count == 4'd15, "R4 inc to top", count, 15);
    check(carry_out == 1'b1, "R6 carry at top", carry_out, 1);
    tick();
    check(count == 4'd0, "R4 wrap", count, 0);
    check(carry_out == 1'b0, "R6 carry drops after wrap", carry_out, 0);
  endtask

  task automatic t_hold();
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0); din = 4'd7;
    tick();
    // R5: each enable alone is not enough
    set_ctl(1'b1, 1'b1, 1'b0, 1'b1);
    tick(); tick();
    check(count == 4'd7, "R5 hold cnt_en low", count, 7);
    set_ctl(1'b1, 1'b1, 1'b1, 1'b0);
    tick(); tick();
    check(count == 4'd7, "R5 hold carry_en low", count, 7);
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    tick();
    check(count == 4'd7, "R5 hold both low", count, 7);
  endtask

  task automatic t_carry();
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0); din = 4'd15;
    tick();
    set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
    #0.5;
    check(carry_out == 1'b0, "R6 carry gated off", carry_out, 0);
    // R6: carry follows carry_en between edges
    carry_en = 1'b1;
    #0.5;
    check(carry_out == 1'b1, "R6 carry comb rise", carry_out, 1);
    carry_en = 1'b0;
    #0.5;
    check(carry_out == 1'b0, "R6 carry comb fall", carry_out, 0);
    // cnt_en alone does not gate the carry
    cnt_en = 1'b0; carry_en = 1'b1;
    #0.5;
    check(carry_out == 1'b1, "R6 carry ignores cnt_en", carry_out, 1);
    carry_en = 1'b0;
    tick();
    check(count == 4'd15, "R5 hold at top", count, 15);
  endtask

  task automatic t_cascade();
    // R7: two stages count 0..255 then wrap
    c_clr_n = 1'b0; c_en = 1'b0;
    tick();
    check({hi_q, lo_q} == 8'd0, "R7 cascade clear", {hi_q, lo_q}, 0);
    c_clr_n = 1'b1; c_en = 1'b1;
    for (int i = 1; i <= 256; i++) begin
      tick();
      check({hi_q, lo_q} == 8'(i), "R7 cascade step", {hi_q, lo_q}, i % 256);
    end
    c_en = 1'b0;
    tick();
    check({hi_q, lo_q} == 8'd0, "R7 cascade hold", {hi_q, lo_q}, 0);
  endtask

  initial begin
    tick();
    t_clear();
    t_load();
    t_count();
    t_hold();
    t_carry();
    t_cascade();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule